// File: doc/BRIEF.md
# System Control Register File

This block is a small bank of system-control words behind a simple 32-bit request/acknowledge register bus. It decodes a 4 KiB byte window. The lower half of the window maps onto 512 words of storage, and each word is selected by the byte offset with its two low bits dropped. Most words simply hold whatever was last written. Four words come out of reset with fixed identification and configuration values. Three read addresses always report bits 29:28 as set. One write address, which lies above the storage, is a command port. Writing it can ask the rest of the chip for a system reset or a power-off.

The storage is a plain single-port array with no reset. After reset, a controller walks every word and writes its initial value. The controller is a three-state machine:
- `ST_CLEAR` fills the array one word per cycle. It moves to `ST_READY` after the last word is written.
- `ST_READY` waits for `req`. When `req` is seen, the access is accepted, the address is decoded, and the machine moves to `ST_RESP`.
- `ST_RESP` drives `ack` for exactly one cycle, together with the read data and any request or error pulse. It then returns to `ST_READY`.

A master holds `req`, `we`, `addr` and `wdata` steady until it sees `ack`.

Top module: `sysctl_regfile`

## Requirements
- R1: Once initialisation finishes, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121 and word 0x43 holds 0x05F40121. Every other word holds zero.
- R2: A write whose word index (addr[11:2]) is below 512 stores all 32 bits of `wdata` at that index. A later read of the same index returns the value. The `rdata` of a write acknowledge is zero.
- R3: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word OR 0x30000000. The stored word itself is unchanged, and no other offset has bits forced.
- R4: A write to word index 0x3C0 (byte offset 0xF00) with data 1 or 2 pulses `rst_req` high for one cycle, in the same cycle as its `ack`.
- R5: A write to word index 0x3C0 with data 3 pulses `off_req` for one cycle with its `ack`. Any other data, or data 3 at any other index, raises neither request.
- R6: A read whose word index is 512 or more returns zero and pulses `acc_err` with its `ack`.
- R7: A write whose word index is 512 or more, including a command write, leaves every stored word unchanged and pulses `acc_err` with its `ack`.
- R8: Address bits 1:0 play no part in decode. An unaligned offset behaves exactly like its containing word, including the command index.
- R9: Each accepted access yields exactly one single-cycle `ack`, one cycle after acceptance. `rst_req`, `off_req` and `acc_err` are never high without `ack`.
- R10: While `rst_n` is low and during the initialisation walk, `ack` and all pulses stay low. A request raised right after reset is acknowledged only after at least 512 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until `ack` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset in the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `ack`, zero otherwise |
| ack | output | 1 | One-cycle access acknowledge |
| rst_req | output | 1 | One-cycle system reset request |
| off_req | output | 1 | One-cycle power-off request |
| acc_err | output | 1 | One-cycle out-of-range access flag |

## Verification
The hardest case to reach from the ports is a command or other out-of-range write that silently lands in storage through a truncated index. Such a write produces the expected pulses, so the corruption shows up only in a different word. To catch it, the stimulus first fills word 0x1C0, which is the 9-bit alias of the command index, and word 0x000 with known values. It then issues command writes and a write at offset 0x800. Finally it reads both aliased words back through the bus. The initialisation walk is checked by timing the very first request after reset, and by reading all 512 words before any write touches them.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned SC_ADDR_W = 12;
    localparam int unsigned SC_DATA_W = 32;
    localparam int unsigned SC_DEPTH  = 512;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_READY = 2'd1,
        ST_RESP  = 2'd2
    } sc_state_e;

    // word indices whose reads report bits 29:28 as set
    localparam int unsigned N_FORCE = 3;
    localparam logic [9:0] FORCE_IDX [N_FORCE] = '{10'h040, 10'h042, 10'h043};
    localparam logic [31:0] FORCE_MASK = 32'h3000_0000;

    // command port word index (byte offset 0xF00)
    localparam logic [9:0] CMD_IDX = 10'h3C0;

    function automatic logic [31:0] init_word(input logic [9:0] idx);
        logic [31:0] v;
        case (idx)
            10'h040: v = 32'h05F2_0121;
            10'h041: v = 32'h0000_0002;
            10'h042: v = 32'h05F3_0121;
            10'h043: v = 32'h05F4_0121;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = SC_ADDR_W,
    parameter int unsigned DEPTH  = SC_DEPTH,
    localparam int unsigned IDX_W  = ADDR_W - 2,
    localparam int unsigned MEM_AW = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [MEM_AW-1:0] mem_idx,
    output logic              in_range,
    output logic              is_cmd,
    output logic              force_hit
);
    logic [IDX_W-1:0]   word_idx;
    logic [N_FORCE-1:0] hits;
    logic               unused_lsb;

    assign word_idx   = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];
    assign mem_idx    = word_idx[MEM_AW-1:0];
    assign in_range   = ({1'b0, word_idx} < (IDX_W + 1)'(DEPTH));
    assign is_cmd     = (word_idx == IDX_W'(CMD_IDX));

    for (genvar g = 0; g < N_FORCE; g++) begin : g_force
        assign hits[g] = (word_idx == IDX_W'(FORCE_IDX[g]));
    end

    assign force_hit = |hits;

endmodule

// File: rtl/sysctl_cmd_dec.sv
module sysctl_cmd_dec
    import sysctl_pkg::*;
#(
    parameter int unsigned DATA_W = SC_DATA_W
) (
    input  logic              is_cmd,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit_rst,
    output logic              hit_off
);
    logic cmd_wr;

    assign cmd_wr  = is_cmd && we;
    assign hit_rst = cmd_wr && ((wdata == DATA_W'(1)) || (wdata == DATA_W'(2)));
    assign hit_off = cmd_wr && (wdata == DATA_W'(3));

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int unsigned DEPTH  = SC_DEPTH,
    parameter int unsigned DATA_W = SC_DATA_W,
    localparam int unsigned MEM_AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_q <= mem_q[rd_addr];
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = SC_ADDR_W,
    parameter int unsigned DATA_W = SC_DATA_W,
    parameter int unsigned DEPTH  = SC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output logic              rst_req,
    output logic              off_req,
    output logic              acc_err
);
    localparam int unsigned MEM_AW = $clog2(DEPTH);
    localparam logic [MEM_AW-1:0] LAST_IDX = MEM_AW'(DEPTH - 1);

    sc_state_e state_q, state_d;

    logic [MEM_AW-1:0] mem_idx;
    logic              in_range, is_cmd, force_hit;
    logic              hit_rst, hit_off;
    logic              accept, clearing, clr_done;

    logic [MEM_AW-1:0] clr_q;
    logic              cap_we_q, cap_inr_q, cap_force_q, cap_rst_q, cap_off_q;

    logic              wr_en, rd_en;
    logic [MEM_AW-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    sysctl_addr_dec #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dec (
        .addr      (addr),
        .mem_idx   (mem_idx),
        .in_range  (in_range),
        .is_cmd    (is_cmd),
        .force_hit (force_hit)
    );

    sysctl_cmd_dec #(.DATA_W(DATA_W)) u_cmd (
        .is_cmd  (is_cmd),
        .we      (we),
        .wdata   (wdata),
        .hit_rst (hit_rst),
        .hit_off (hit_off)
    );

    sysctl_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (mem_idx),
        .rd_data (rd_data)
    );

    assign clearing = (state_q == ST_CLEAR);
    assign clr_done = clearing && (clr_q == LAST_IDX);
    assign accept   = (state_q == ST_READY) && req;

    // storage port: initialisation walk has priority over bus writes
    assign wr_en   = clearing || (accept && we && in_range);
    assign wr_addr = clearing ? clr_q : mem_idx;
    assign wr_data = clearing ? DATA_W'(init_word(10'(clr_q))) : wdata;
    assign rd_en   = accept && !we && in_range;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (clr_done) state_d = ST_READY;
            ST_READY: if (req)      state_d = ST_RESP;
            ST_RESP:                state_d = ST_READY;
            default:                state_d = ST_CLEAR;
        endcase
    end

    // walk counter and access capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q       <= '0;
            cap_we_q    <= 1'b0;
            cap_inr_q   <= 1'b0;
            cap_force_q <= 1'b0;
            cap_rst_q   <= 1'b0;
            cap_off_q   <= 1'b0;
        end else begin
            if (clearing) begin
                clr_q <= clr_q + MEM_AW'(1);
            end
            if (accept) begin
                cap_we_q    <= we;
                cap_inr_q   <= in_range;
                cap_force_q <= force_hit;
                cap_rst_q   <= hit_rst;
                cap_off_q   <= hit_off;
            end
        end
    end

    // outputs
    always_comb begin
        ack     = 1'b0;
        rdata   = '0;
        rst_req = 1'b0;
        off_req = 1'b0;
        acc_err = 1'b0;
        unique case (state_q)
            ST_RESP: begin
                ack     = 1'b1;
                rst_req = cap_rst_q;
                off_req = cap_off_q;
                acc_err = !cap_inr_q;
                if (!cap_we_q && cap_inr_q) begin
                    rdata = rd_data | (cap_force_q ? DATA_W'(FORCE_MASK) : '0);
                end
            end
            ST_CLEAR, ST_READY: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = SC_ADDR_W,
    parameter int unsigned DATA_W = SC_DATA_W,
    parameter int unsigned DEPTH  = SC_DEPTH
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              ack,
    input logic              rst_req,
    input logic              off_req,
    input logic              acc_err
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_ack_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req));

    p_pulse_needs_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || off_req || acc_err) |-> ack);

    p_rst_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(we) && ($past(addr[ADDR_W-1:2]) == IDX_W'(CMD_IDX))
                     && (($past(wdata) == DATA_W'(1)) || ($past(wdata) == DATA_W'(2)))));

    p_off_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |-> ($past(we) && ($past(addr[ADDR_W-1:2]) == IDX_W'(CMD_IDX))
                     && ($past(wdata) == DATA_W'(3))));

    p_req_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && off_req));

    p_oor_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && acc_err) |-> (rdata == '0));

    p_err_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> ({1'b0, $past(addr[ADDR_W-1:2])} >= (IDX_W + 1)'(DEPTH)));

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .we      (we),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .ack     (ack),
    .rst_req (rst_req),
    .off_req (off_req),
    .acc_err (acc_err)
);

// File: tb/sysctl_regfile_tb_top.sv
module sysctl_regfile_tb_top;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        logic        rst;
        logic        off;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack, rst_req, off_req, acc_err;

    int n_chk = 0;
    int n_err = 0;
    exp_t expq[$];
    logic [31:0] mdl [512];

    always #2 clk = ~clk;

    sysctl_regfile dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .ack     (ack),
        .rst_req (rst_req),
        .off_req (off_req),
        .acc_err (acc_err)
    );

    function automatic bit forced(input logic [9:0] idx);
        return (idx == 10'h040) || (idx == 10'h042) || (idx == 10'h043);
    endfunction

    task automatic finish_run();
        if (expq.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL R9 outstanding acks: actual=%0d expected=0", expq.size());
        end
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    task automatic do_access(input logic w, input logic [11:0] a, input logic [31:0] d,
                             input string tag, output int cyc);
        exp_t e;
        logic [9:0] idx;
        bit inr, cmd;
        idx = a[11:2];
        inr = (idx < 10'd512);
        cmd = w && (idx == 10'h3C0);
        e.err = !inr;
        e.rst = cmd && ((d == 32'd1) || (d == 32'd2));
        e.off = cmd && (d == 32'd3);
        e.tag = tag;
        if (w) begin
            e.rdata = '0;
            if (inr) mdl[idx[8:0]] = d;
        end else begin
            e.rdata = inr ? (mdl[idx[8:0]] | (forced(idx) ? 32'h3000_0000 : 32'h0)) : 32'h0;
        end
        expq.push_back(e);
        req = 1'b1; we = w; addr = a; wdata = d;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!ack);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        int c;
        do_access(1'b1, a, d, tag, c);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        int c;
        do_access(1'b0, a, 32'h0, tag, c);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (ack) begin
                if (expq.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL R9 unexpected ack: actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    n_chk++;
                    if (rdata !== e.rdata || acc_err !== e.err ||
                        rst_req !== e.rst || off_req !== e.off) begin
                        n_err++;
                        $display("FAIL %s: actual rdata=%h err=%b rst=%b off=%b expected rdata=%h err=%b rst=%b off=%b",
                                 e.tag, rdata, acc_err, rst_req, off_req,
                                 e.rdata, e.err, e.rst, e.off);
                    end
                end
            end else if (rst_req || off_req || acc_err) begin
                n_chk++; n_err++;
                $display("FAIL R9 pulse without ack: actual rst=%b off=%b err=%b expected 0",
                         rst_req, off_req, acc_err);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R9 watchdog expired: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int cyc;
        for (int i = 0; i < 512; i++) mdl[i] = 32'h0;
        mdl[9'h040] = 32'h05F2_0121;
        mdl[9'h041] = 32'h0000_0002;
        mdl[9'h042] = 32'h05F3_0121;
        mdl[9'h043] = 32'h05F4_0121;

        // R10: quiet outputs while reset is held
        repeat (4) @(negedge clk);
        n_chk++;
        if (ack !== 1'b0 || rdata !== 32'h0 || rst_req !== 1'b0 ||
            off_req !== 1'b0 || acc_err !== 1'b0) begin
            n_err++;
            $display("FAIL R10 reset state: actual ack=%b rdata=%h rst=%b off=%b err=%b expected all 0",
                     ack, rdata, rst_req, off_req, acc_err);
        end
        rst_n = 1'b1;

        // R10: first request waits out the initialisation walk; R1 value of word 0x41
        do_access(1'b0, 12'h104, 32'h0, "R10 first read after reset", cyc);
        n_chk++;
        if (cyc < 512) begin
            n_err++;
            $display("FAIL R10 init latency: actual=%0d expected>=512", cyc);
        end

        // R1 and R3: every word after initialisation
        for (int i = 0; i < 512; i++) rd(12'(i * 4), "R1 init value sweep");

        // R2: full-width stores
        wr(12'h000, 32'hA5A5_5A5A, "R2 write 0x000");
        rd(12'h000, "R2 readback 0x000");
        wr(12'h7FC, 32'hFFFF_FFFF, "R2 write top word");
        rd(12'h7FC, "R2 readback top word");
        wr(12'h3F0, 32'h8000_0001, "R2 write 0x3F0");
        rd(12'h3F0, "R2 readback 0x3F0");

        // R3: forced bits on read only
        wr(12'h100, 32'h0000_0000, "R3 clear forced word");
        rd(12'h100, "R3 forced read 0x100");
        wr(12'h108, 32'h1234_5678, "R3 write 0x108");
        rd(12'h108, "R3 forced read 0x108");
        wr(12'h10C, 32'hCFFF_FFFF, "R3 write 0x10C");
        rd(12'h10C, "R3 forced read 0x10C");
        wr(12'h104, 32'h0000_0000, "R3 write 0x104");
        rd(12'h104, "R3 unforced read 0x104");
        rd(12'h110, "R3 unforced read 0x110");

        // R8: low address bits ignored
        wr(12'h203, 32'hDEAD_BEEF, "R8 unaligned write");
        rd(12'h200, "R8 aligned readback");
        rd(12'h201, "R8 unaligned readback");
        rd(12'h10A, "R8 unaligned forced read");

        // R4 / R5: command decode
        wr(12'h700, 32'h1357_9BDF, "R7 preset alias word 0x1C0");
        wr(12'hF00, 32'd1, "R4 command value 1");
        wr(12'hF00, 32'd2, "R4 command value 2");
        wr(12'hF00, 32'd3, "R5 command value 3");
        wr(12'hF00, 32'd0, "R5 command value 0");
        wr(12'hF00, 32'd4, "R5 command value 4");
        wr(12'hF00, 32'h0000_0103, "R5 command value 0x103");
        wr(12'hF02, 32'd3, "R8 unaligned command 3");
        wr(12'hF03, 32'd1, "R8 unaligned command 1");
        wr(12'h300, 32'd3, "R5 value 3 in storage");
        rd(12'h300, "R5 readback 0x300");

        // R7: out-of-range writes leave storage alone
        rd(12'h700, "R7 alias word after commands");
        wr(12'h800, 32'hBAD0_BAD0, "R7 write 0x800");
        rd(12'h000, "R7 word 0 after 0x800 write");
        wr(12'hFFC, 32'h7777_7777, "R7 write 0xFFC");
        rd(12'h7FC, "R7 top word after 0xFFC write");

        // R6: out-of-range reads
        rd(12'hF00, "R6 read command offset");
        rd(12'h800, "R6 read 0x800");
        rd(12'hFFF, "R6 read 0xFFF");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule